// File: doc/BRIEF.md
# Serial Receive Engine with Break Handling

This block turns an asynchronous serial line into received characters. A one-cycle enable, `rx_tick`, runs at sixteen times the bit rate. The engine finds the falling edge of a start bit and confirms it at the middle of that bit. It then samples every later bit at its centre and assembles a character of five to eight data bits, least significant bit first. The character may carry a parity bit and one or two stop bits. Each finished character leaves on a one-cycle strobe, together with three tags: break, framing error and parity error.

A line held low for longer than a whole frame is a break. The engine reports each break as one all-zero character tagged as both a break and a framing error. It then waits until the line has been high for a full bit time before it looks for another start bit. When a stop bit reads low on a character that is not all zeros, the engine takes that low level as the start bit of the next character and keeps receiving from there.

Top module: `serial_rx_engine`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_data` and `out_tags` are 0 until a character completes.
- R2: If a start bit reads high when sampled at its middle (the eighth tick after the falling edge is seen), it is discarded and no character is produced.
- R3: `cfg_len` selects the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Bits arrive LSB first, and the bits of `out_data` above the selected length are 0.
- R4: With `cfg_par_en` set, one parity bit follows the data. `cfg_par_odd`=0 means even parity and 1 means odd parity. A mismatch sets the parity tag, `out_tags[0]`.
- R5: `cfg_two_stop` selects two stop bits instead of one. Any stop bit that samples low sets the framing tag, `out_tags[1]`. A character without that tag had its last stop bit sampled high.
- R6: When a stop bit samples low and the data or parity bits held a 1, the character is emitted with the framing tag. The low stop-bit slot is then taken as the start bit of the next character, and that character's data is sampled one bit time later.
- R7: A break is a line held low from the start bit through every sample and for a further full bit time past the failing stop sample. It yields data 0x00 with tags 3'b110: break `out_tags[2]`, framing set, parity clear.
- R8: One break, however long, yields exactly one character. No further character is assembled until the line has been high for 16 consecutive ticks. A shorter high pulse during the break restarts that count.
- R9: An all-zero frame whose stop bit samples low, but whose line rises before the break is confirmed, is emitted as 0x00 with the framing tag only. It is not a break.
- R10: `out_valid` lasts exactly one clock and only in the cycle after an `rx_tick`. The tags read {break, framing, parity} on bits 2 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length select (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when set, even otherwise |
| cfg_two_stop | input | 1 | Two stop bits when set |
| out_valid | output | 1 | One-cycle strobe for a received character |
| out_data | output | 8 | Received character, zero-extended |
| out_tags | output | 3 | {break, framing error, parity error} |

## Verification
The bench aims at the places where a receiver with break handling usually goes wrong.

- **Long break.** A break that lasts well past a frame, with a short high blip inside it, must still yield one character. A design that re-arms too early would emit extra zero characters.
- **Bad stop bit on non-zero data.** Such a frame must be followed at once by a character built from the following bits. A design that waits for idle would lose that character or produce garbage.
- **All-zero frame that rises after its bad stop.** This must read as a plain framing error. A design that calls a break on the stop sample alone would wrongly set the break tag.
- **Other cases.** The bench also covers start-bit glitches, every data length, both parity senses with forced mismatches, and a failing second stop bit.

// File: rtl/rxeng_pkg.sv
package rxeng_pkg;

  localparam int CHAR_MAX = 8;
  localparam int TAG_W    = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BRKCHK,
    S_BRKWAIT
  } rx_state_t;

  // number of data bits for a length select code
  function automatic logic [3:0] char_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  // 1 when the received parity bit disagrees with the selected sense
  function automatic logic par_mismatch(input logic [CHAR_MAX-1:0] d,
                                        input logic pbit,
                                        input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/rxeng_sync.sv
module rxeng_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rxeng_shift.sv
module rxeng_shift #(
  parameter  int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [IW-1:0] idx,
  input  logic          din,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q[idx] <= din;
  end
endmodule

// File: rtl/rxeng_core.sv
module rxeng_core
  import rxeng_pkg::*;
#(
  parameter  int OSR = 16,
  localparam int CW  = $clog2(OSR),
  localparam int MID = OSR / 2,
  localparam int IW  = $clog2(CHAR_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic [CHAR_MAX-1:0] data_q,
  output logic                sh_clr,
  output logic                sh_load,
  output logic [IW-1:0]       sh_idx,
  output logic                sh_din,
  output logic                brk_evt,
  output logic                out_valid,
  output logic [CHAR_MAX-1:0] out_data,
  output logic [TAG_W-1:0]    out_tags
);
  rx_state_t st;
  logic [CW-1:0] tcnt;
  logic [3:0]    bitn;
  logic          two_done, pbit_q, perr_q;

  logic       last, midp, zero_frame;
  logic [3:0] nbits;

  assign last       = (tcnt == CW'(OSR - 1));
  assign midp       = (tcnt == CW'(MID - 1));
  assign nbits      = char_bits(cfg_len);
  assign zero_frame = (data_q == '0) && !pbit_q;

  assign sh_load = tick && last && (st == S_DATA);
  assign sh_din  = rx;
  assign sh_idx  = bitn[IW-1:0];
  assign sh_clr  = tick && (((st == S_START) && midp && !rx) ||
                            ((st == S_STOP) && last && !rx && !zero_frame));
  assign brk_evt = tick && (st == S_BRKCHK) && !rx && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tcnt      <= '0;
      bitn      <= '0;
      two_done  <= 1'b0;
      pbit_q    <= 1'b0;
      perr_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tags  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        unique case (st)
          S_IDLE: if (!rx) begin
            st   <= S_START;
            tcnt <= '0;
          end
          S_START: if (midp) begin
            if (rx) st <= S_IDLE;
            else begin
              st       <= S_DATA;
              tcnt     <= '0;
              bitn     <= '0;
              pbit_q   <= 1'b0;
              perr_q   <= 1'b0;
              two_done <= 1'b0;
            end
          end else tcnt <= tcnt + CW'(1);
          S_DATA: if (last) begin
            tcnt <= '0;
            bitn <= bitn + 4'd1;
            if (bitn == nbits - 4'd1) st <= cfg_par_en ? S_PAR : S_STOP;
          end else tcnt <= tcnt + CW'(1);
          S_PAR: if (last) begin
            tcnt   <= '0;
            pbit_q <= rx;
            perr_q <= par_mismatch(data_q, rx, cfg_par_odd);
            st     <= S_STOP;
          end else tcnt <= tcnt + CW'(1);
          S_STOP: if (last) begin
            tcnt <= '0;
            if (!rx) begin
              if (zero_frame) st <= S_BRKCHK;
              else begin
                out_valid <= 1'b1;
                out_data  <= data_q;
                out_tags  <= {1'b0, 1'b1, perr_q};
                st        <= S_DATA;          // low slot becomes next start
                bitn      <= '0;
                pbit_q    <= 1'b0;
                perr_q    <= 1'b0;
                two_done  <= 1'b0;
              end
            end else if (cfg_two_stop && !two_done) begin
              two_done <= 1'b1;
            end else begin
              out_valid <= 1'b1;
              out_data  <= data_q;
              out_tags  <= {1'b0, 1'b0, perr_q};
              st        <= S_IDLE;
            end
          end else tcnt <= tcnt + CW'(1);
          S_BRKCHK: if (rx) begin
            out_valid <= 1'b1;
            out_data  <= data_q;
            out_tags  <= {1'b0, 1'b1, perr_q};
            st        <= S_IDLE;
          end else if (last) begin
            out_valid <= 1'b1;
            out_data  <= '0;
            out_tags  <= 3'b110;
            st        <= S_BRKWAIT;
            tcnt      <= '0;
          end else tcnt <= tcnt + CW'(1);
          S_BRKWAIT: if (!rx)  tcnt <= '0;
                     else if (last) st <= S_IDLE;
                     else tcnt <= tcnt + CW'(1);
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import rxeng_pkg::*;
#(
  parameter  int OSR         = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int IW          = $clog2(CHAR_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_tick,
  input  logic                rx_line,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  output logic                out_valid,
  output logic [CHAR_MAX-1:0] out_data,
  output logic [TAG_W-1:0]    out_tags
);
  logic                rx_s;
  logic                sh_clr, sh_load, sh_din;
  logic [IW-1:0]       sh_idx;
  logic [CHAR_MAX-1:0] data_q;
  logic                brk_evt;

  rxeng_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  rxeng_shift #(.W(CHAR_MAX)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load),
    .idx(sh_idx), .din(sh_din), .q(data_q)
  );

  rxeng_core #(.OSR(OSR)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rx(rx_s),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .data_q(data_q),
    .sh_clr(sh_clr), .sh_load(sh_load), .sh_idx(sh_idx), .sh_din(sh_din),
    .brk_evt(brk_evt), .out_valid(out_valid), .out_data(out_data),
    .out_tags(out_tags)
  );
endmodule

// File: rtl/rxeng_chk.sv
module rxeng_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_tick,
  input logic       rx_s,
  input logic       brk_evt,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic [2:0] out_tags
);
  // R10: strobe lasts one clock
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R10: strobe follows an oversampling tick
  assert_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rx_tick));

  // R7: break character is zero, framing set, parity clear
  assert_break_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tags[2]) |-> (out_tags[1] && !out_tags[0] && out_data == 8'h00));

  // R7: break decided while the line was low
  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tags[2]) |-> !$past(rx_s));

  // R5: a clean character saw its final stop bit high
  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_tags[1]) |-> $past(rx_s));

  // R8: a confirmed break reaches the output as one break character
  assert_break_emits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> (out_valid && out_tags[2]));
endmodule

bind serial_rx_engine rxeng_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_s(rx_s),
  .brk_evt(brk_evt), .out_valid(out_valid), .out_data(out_data),
  .out_tags(out_tags)
);

// File: tb/serial_rx_engine_tb_top.sv
`timescale 1ns/1ps
module serial_rx_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic [2:0] out_tags;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int tdiv = 0;
  logic prev_v = 1'b0;

  logic [10:0] expq[$];   // {tags, data}
  string       tagq[$];

  always #2.5 clk = ~clk;   // 200 MHz

  serial_rx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .out_valid(out_valid),
    .out_data(out_data), .out_tags(out_tags)
  );

  // oversampling enable: one tick every 4 clocks
  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv    <= 0;
      rx_tick <= 1'b0;
    end else begin
      tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
      rx_tick <= (tdiv == 3);
    end
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (prev_v) begin
          errors++;
          $display("FAIL R10: strobe longer than one clock (actual 2 cycles, expected 1)");
        end
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R8: unexpected character actual tags=%b data=%h, expected none",
                   out_tags, out_data);
        end else begin
          logic [10:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if ({out_tags, out_data} !== e)
            begin
              errors++;
              $display("FAIL %s: actual tags=%b data=%h, expected tags=%b data=%h",
                       t, out_tags, out_data, e[10:8], e[7:0]);
            end
        end
      end
      prev_v = out_valid;
    end
  end

  task automatic hold_line(input logic v, input int ticks);
    rx_line = v;
    repeat (ticks * 4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int len, input logic pen,
                            input logic podd, input logic two, input logic bad_par,
                            input logic bad_s1, input logic bad_s2,
                            input logic skip_start, input string tag);
    logic [7:0] m;
    logic       pb, fe;
    m  = 8'hFF >> (8 - len);
    pb = (^(d & m)) ^ podd ^ bad_par;
    fe = bad_s1 | (two & bad_s2);
    cfg_len      = 2'(len - 5);
    cfg_par_en   = pen;
    cfg_par_odd  = podd;
    cfg_two_stop = two;
    expq.push_back({1'b0, fe, pen & bad_par, d & m});
    tagq.push_back(tag);
    if (!skip_start) hold_line(1'b0, 16);
    for (int i = 0; i < len; i++) hold_line(d[i], 16);
    if (pen) hold_line(pb, 16);
    hold_line(!bad_s1, 16);
    if (two && !bad_s1) hold_line(!bad_s2, 16);
  endtask

  task automatic expect_char(input logic [2:0] tg, input logic [7:0] d, input string tag);
    expq.push_back({tg, d});
    tagq.push_back(tag);
  endtask

  task automatic gap();
    hold_line(1'b1, 32);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 8'h00 || out_tags !== 3'b000) begin
      errors++;
      $display("FAIL R1: in reset actual v=%b d=%h t=%b, expected 0 00 000",
               out_valid, out_data, out_tags);
    end
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 8'h00 || out_tags !== 3'b000) begin
      errors++;
      $display("FAIL R1: after reset actual v=%b d=%h t=%b, expected 0 00 000",
               out_valid, out_data, out_tags);
    end
    gap();

    // R3: each data length
    send_frame(8'hA5, 8, 0, 0, 0, 0, 0, 0, 0, "R3 8-bit"); gap();
    send_frame(8'h13, 5, 0, 0, 0, 0, 0, 0, 0, "R3 5-bit"); gap();
    send_frame(8'h2C, 6, 0, 0, 0, 0, 0, 0, 0, "R3 6-bit"); gap();
    send_frame(8'h5A, 7, 0, 0, 0, 0, 0, 0, 0, "R3 7-bit"); gap();

    // R4: parity senses, good and forced bad
    send_frame(8'h3C, 8, 1, 0, 0, 0, 0, 0, 0, "R4 even ok");  gap();
    send_frame(8'h3D, 8, 1, 0, 0, 1, 0, 0, 0, "R4 even bad"); gap();
    send_frame(8'h41, 7, 1, 1, 0, 0, 0, 0, 0, "R4 odd ok");   gap();
    send_frame(8'h40, 7, 1, 1, 0, 1, 0, 0, 0, "R4 odd bad");  gap();

    // R5: two stop bits, good then failing second stop with resync
    send_frame(8'h96, 8, 0, 0, 1, 0, 0, 0, 0, "R5 two stop"); gap();
    send_frame(8'h81, 8, 0, 0, 1, 0, 0, 1, 0, "R5 second stop low");
    send_frame(8'h7E, 8, 0, 0, 1, 0, 0, 0, 1, "R6 after second stop"); gap();

    // R2: start glitch, then a real character
    hold_line(1'b0, 4);
    hold_line(1'b1, 40);
    send_frame(8'h33, 8, 0, 0, 0, 0, 0, 0, 0, "R2 after glitch"); gap();

    // R6: bad stop, next character starts in the stop slot
    send_frame(8'hC3, 8, 0, 0, 0, 0, 1, 0, 0, "R6 bad stop");
    send_frame(8'h18, 8, 0, 0, 0, 0, 0, 0, 1, "R6 resync char"); gap();

    // R9: zero frame, stop low, line rises before break is confirmed
    send_frame(8'h00, 8, 0, 0, 0, 0, 1, 0, 0, "R9 zero framing only"); gap();

    // R7: break, then a normal character
    cfg_len = 2'd3; cfg_par_en = 0; cfg_two_stop = 0;
    expect_char(3'b110, 8'h00, "R7 break");
    hold_line(1'b0, 16 * 24);
    hold_line(1'b1, 32);
    send_frame(8'h5A, 8, 0, 0, 0, 0, 0, 0, 0, "R7 after break"); gap();

    // R8: long break with a short high blip inside
    cfg_len = 2'd3; cfg_par_en = 0;
    expect_char(3'b110, 8'h00, "R8 single break");
    hold_line(1'b0, 16 * 24);
    hold_line(1'b1, 8);
    hold_line(1'b0, 16 * 30);
    hold_line(1'b1, 32);
    send_frame(8'hA5, 8, 0, 0, 0, 0, 0, 0, 0, "R8 after long break"); gap();

    // R7: break with even parity and 7 data bits
    cfg_len = 2'd2; cfg_par_en = 1; cfg_par_odd = 0;
    expect_char(3'b110, 8'h00, "R7 break with parity");
    hold_line(1'b0, 16 * 20);
    hold_line(1'b1, 32);
    gap();

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R8: %0d characters missing, expected 0", expq.size());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule